// File: doc/BRIEF.md
# Edge-Triggered Interrupt Collector with Message Write-Out

The block gathers up to eleven interrupt lines from devices below it and turns any change on an enabled line into one posted write message toward a processor. Each line passes through a two-flop synchroniser. A change in either direction on a line that is enabled and implemented sets that line's pending bit. It also starts a message request, unless a request is already outstanding. The message carries an address and data taken from one programmable target word. The low field of that word is the data and the rest is the address.

Software programs the target word and the enable mask over a simple word-indexed register port. It collects pending lines through two read-to-clear views, and it reads the live, synchronised line levels. A line that is already high when it is enabled raises nothing. Software that wants level behaviour compares the level view with the mask after it unmasks a line. Changes that arrive while a message is outstanding are folded into the pending bits, and exactly one follow-up message is sent once the outstanding one is acknowledged.

Top module: `irq_msg_aggregator`

## Requirements
- R1: After reset the target word (index 0), the mask (index 1) and all pending bits read as zero, and msg_req_o is low.
- R2: The mask at word index 1 is written and read back with one enable bit per line (bit n enables line n). While the mask is all zero, no line change sets a pending bit or raises msg_req_o.
- R3: A rising or a falling change on an enabled, implemented line sets its pending bit. If no message is outstanding, it raises msg_req_o within four clock cycles of the change.
- R4: A change on a disabled line sets nothing. A line that is already asserted when its mask bit is set produces no pending bit and no message.
- R5: A read of word index 2 returns the pending bits ANDed with 0x5FF and clears those bits in the same access.
- R6: A read of word index 3 also returns the pending bits ANDed with 0x5FF and clears them. A write to index 3 clears every pending bit written as 1.
- R7: Only lines 0 to 8 and line 10 are implemented. Line 9 never sets a pending bit, never reads as set, and never starts a message.
- R8: Word index 4 returns the synchronised level of all eleven lines (bit n = line n). It follows the inputs whatever the pending state, and clearing reads leave it unchanged.
- R9: A message uses msg_data_o = target[4:0] and msg_addr_o = target with bits 4:0 forced to zero, both captured when the request starts.
- R10: msg_req_o stays high with stable msg_addr_o and msg_data_o until msg_ack_i is sampled high. It is low in the cycle after the acknowledge.
- R11: Any number of changes that arrive while a message is outstanding lead to exactly one further message after the acknowledge. Their pending bits accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 11 | Asynchronous interrupt lines, bit n = line n |
| reg_req_i | input | 1 | Register access strobe, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_idx_i | input | 3 | Word index of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the access |
| msg_req_o | output | 1 | Message request, held until acknowledged |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |
| msg_ack_i | input | 1 | Message acknowledge |

## Verification
The bench builds the block with its default values: eleven lines, implemented-line mask 0x5FF and a five-bit data field. Every line is then swept one at a time through both rising and falling changes, with the mask both set and cleared. This covers the missing line 9 and the serial line 10 explicitly. The fixed three-stage detect path also puts the merge of several changes during one outstanding message within reach of short, cycle-exact sequences.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    IDX_TARGET = 3'd0,
    IDX_MASK   = 3'd1,
    IDX_CLAIM  = 3'd2,
    IDX_PACK   = 3'd3,
    IDX_LEVEL  = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] change_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= line_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign level_o[g]  = s2_q;
    assign change_o[g] = s2_q ^ prev_q;
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
#(
  parameter int          N    = 11,
  parameter logic [N-1:0] IMPL = 11'h5FF,
  parameter int          DW   = 32,
  parameter int          IW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [N-1:0]  change_i,
  input  logic [N-1:0]  level_i,
  output logic [DW-1:0] target_o,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  pend_o,
  output logic          event_o
);
  logic [DW-1:0] target_q;
  logic [N-1:0]  mask_q, pend_q, set_w, clr_w, vis_w;
  logic          rd_w, wr_w;

  assign rd_w  = req_i & ~we_i;
  assign wr_w  = req_i & we_i;
  assign vis_w = pend_q & IMPL;
  assign set_w = change_i & mask_q & IMPL;

  always_comb begin
    clr_w = '0;
    if (rd_w && (idx_i == IDX_CLAIM || idx_i == IDX_PACK)) clr_w = vis_w;
    if (wr_w && idx_i == IDX_PACK) clr_w = wdata_i[N-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
      mask_q   <= '0;
      pend_q   <= '0;
    end else begin
      if (wr_w && idx_i == IDX_TARGET) target_q <= wdata_i;
      if (wr_w && idx_i == IDX_MASK)   mask_q   <= wdata_i[N-1:0];
      pend_q <= (pend_q & ~clr_w) | set_w;  // a new change wins over a clear
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_w) begin
      case (idx_i)
        IDX_TARGET:          rdata_o = target_q;
        IDX_MASK:            rdata_o[N-1:0] = mask_q;
        IDX_CLAIM, IDX_PACK: rdata_o[N-1:0] = vis_w;
        IDX_LEVEL:           rdata_o[N-1:0] = level_i;
        default:             rdata_o = '0;
      endcase
    end
  end

  assign target_o = target_q;
  assign mask_o   = mask_q;
  assign pend_o   = pend_q;
  assign event_o  = |set_w;
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl #(
  parameter int DW     = 32,
  parameter int DATA_W = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] target_i,
  input  logic          event_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          deferred_o
);
  localparam logic [DW-1:0] DMASK = DW'((64'd1 << DATA_W) - 64'd1);

  logic          req_q, defer_q, launch_w;
  logic [DW-1:0] addr_q, data_q;

  assign launch_w = ~req_q & (event_i | defer_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      defer_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (launch_w) begin
        req_q   <= 1'b1;
        defer_q <= 1'b0;
        addr_q  <= target_i & ~DMASK;
        data_q  <= target_i & DMASK;
      end else if (req_q) begin
        if (ack_i) req_q <= 1'b0;
        if (event_i) defer_q <= 1'b1;  // merge into one follow-up message
      end
    end
  end

  assign req_o      = req_q;
  assign addr_o     = addr_q;
  assign data_o     = data_q;
  assign deferred_o = defer_q;
endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator #(
  parameter int           N      = 11,
  parameter logic [N-1:0] IMPL   = 11'h5FF,
  parameter int           DW     = 32,
  parameter int           IW     = 3,
  parameter int           DATA_W = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_lines_i,
  input  logic          reg_req_i,
  input  logic          reg_we_i,
  input  logic [IW-1:0] reg_idx_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          msg_req_o,
  output logic [DW-1:0] msg_addr_o,
  output logic [DW-1:0] msg_data_o,
  input  logic          msg_ack_i
);
  logic [N-1:0]  level_w, change_w, mask_w, pend_w;
  logic [DW-1:0] target_w;
  logic          event_w, deferred_w;

  irq_sync_edge #(.N(N)) u_sync (
    .clk_i, .rst_ni, .line_i(irq_lines_i), .level_o(level_w), .change_o(change_w)
  );

  irq_regfile #(.N(N), .IMPL(IMPL), .DW(DW), .IW(IW)) u_regs (
    .clk_i, .rst_ni, .req_i(reg_req_i), .we_i(reg_we_i), .idx_i(reg_idx_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .change_i(change_w),
    .level_i(level_w), .target_o(target_w), .mask_o(mask_w), .pend_o(pend_w),
    .event_o(event_w)
  );

  irq_msg_ctrl #(.DW(DW), .DATA_W(DATA_W)) u_msg (
    .clk_i, .rst_ni, .target_i(target_w), .event_i(event_w), .ack_i(msg_ack_i),
    .req_o(msg_req_o), .addr_o(msg_addr_o), .data_o(msg_data_o),
    .deferred_o(deferred_w)
  );
endmodule

// File: rtl/irq_msg_aggregator_chk.sv
module irq_msg_aggregator_chk #(
  parameter int N  = 11,
  parameter int DW = 32,
  parameter int IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_req_i,
  input logic          reg_we_i,
  input logic [IW-1:0] reg_idx_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic          msg_req_o,
  input logic [DW-1:0] msg_addr_o,
  input logic [DW-1:0] msg_data_o,
  input logic          msg_ack_i,
  input logic [N-1:0]  mask_w,
  input logic [N-1:0]  pend_w,
  input logic          deferred_w
);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_o && !msg_ack_i |=> msg_req_o);
  a_r10_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_o && !msg_ack_i |=> $stable(msg_addr_o) && $stable(msg_data_o));
  a_r10_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_o && msg_ack_i |=> !msg_req_o);
  a_r7_no_line9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && !reg_we_i && (reg_idx_i == 3'd2 || reg_idx_i == 3'd3)
      |-> reg_rdata_o[9] == 1'b0);
  a_r2_zero_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_req_o && !deferred_w && mask_w == '0 |=> !msg_req_o);
  a_r4_masked_no_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_w == '0 && !reg_req_i |=> (pend_w & ~$past(pend_w)) == '0);
endmodule

bind irq_msg_aggregator irq_msg_aggregator_chk #(.N(N), .DW(DW), .IW(IW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_req_i(reg_req_i), .reg_we_i(reg_we_i),
  .reg_idx_i(reg_idx_i), .reg_rdata_o(reg_rdata_o), .msg_req_o(msg_req_o),
  .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o), .msg_ack_i(msg_ack_i),
  .mask_w(mask_w), .pend_w(pend_w), .deferred_w(deferred_w)
);

// File: tb/test_irq_msg_aggregator.sv
`timescale 1ns/1ps
module test_irq_msg_aggregator;
  localparam int N = 11;
  localparam logic [10:0] IMPL = 11'h5FF;
  localparam logic [31:0] TGT = 32'hF000_1234;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] lines = '0;
  logic req = 1'b0, we = 1'b0, ack = 1'b0;
  logic [2:0] idx = '0;
  logic [31:0] wdata = '0, rdata, maddr, mdata;
  logic mreq;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_msg_aggregator i_irq_msg_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .reg_req_i(req),
    .reg_we_i(we), .reg_idx_i(idx), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .msg_req_o(mreq), .msg_addr_o(maddr), .msg_data_o(mdata), .msg_ack_i(ack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; idx = i; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; idx = i;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_ack;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  initial begin
    #3_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    wait_cyc(3); rst_n = 1; wait_cyc(2);
    // R1 reset state
    rd(0, v); check("R1 target", v, 0);
    rd(1, v); check("R1 mask", v, 0);
    rd(2, v); check("R1 pending", v, 0);
    check("R1 msg_req", {31'd0, mreq}, 0);
    wr(0, TGT);
    // R2 mask readback
    wr(1, 32'h7FF); rd(1, v); check("R2 mask readback", v, 32'h7FF);
    wr(1, 0);
    // R2 zero mask: toggles do nothing
    lines = 11'h7FF; wait_cyc(5);
    check("R2 zero mask no req", {31'd0, mreq}, 0);
    rd(2, v); check("R2 zero mask no pend", v, 0);
    lines = '0; wait_cyc(5);
    // R3/R4/R5/R7/R9 sweep every line, both edges
    for (int i = 0; i < N; i++) begin
      logic [31:0] exp;
      exp = 32'(IMPL & (11'd1 << i));
      wr(1, 32'd1 << i);
      for (int e = 0; e < 2; e++) begin
        lines[i] = (e == 0);
        lines[(i + 1) % N] = (e == 0);  // disabled neighbour, R4
        wait_cyc(4);
        check($sformatf("R3 R7 req line %0d edge %0d", i, e), {31'd0, mreq}, (exp != 0));
        if (mreq) begin
          check("R9 addr", maddr, TGT & ~32'h1F);
          check("R9 data", mdata, TGT & 32'h1F);
        end
        rd((e == 0) ? 3'd2 : 3'd3, v);
        check($sformatf("R5 R6 R7 pend line %0d edge %0d", i, e), v, exp);
        rd(2, v); check("R5 cleared", v, 0);
        if (mreq) do_ack;
        wait_cyc(1);
        check("R10 dropped", {31'd0, mreq}, 0);
      end
    end
    // R4 asserted before unmask
    wr(1, 0); lines = 11'h008; wait_cyc(5);
    wr(1, 32'h008); wait_cyc(5);
    check("R4 preasserted no req", {31'd0, mreq}, 0);
    rd(2, v); check("R4 preasserted no pend", v, 0);
    lines = '0; wait_cyc(5); rd(2, v); if (mreq) do_ack; wait_cyc(2);
    // R8 level view, unaffected by clearing reads
    wr(1, 0); lines = 11'h2A5; wait_cyc(4);
    rd(4, v); check("R8 level", v, 32'h2A5);
    rd(2, v); rd(3, v); rd(4, v); check("R8 level after clears", v, 32'h2A5);
    lines = '0; wait_cyc(4); rd(4, v); check("R8 level low", v, 0);
    // R6 write-one-to-clear
    wr(1, 32'h7FF); lines = 11'h030; wait_cyc(5);
    wr(3, 32'h010); rd(3, v); check("R6 w1c", v, 32'h020);
    if (mreq) do_ack; wait_cyc(1);
    lines = '0; wait_cyc(5); rd(2, v); if (mreq) do_ack; wait_cyc(3);
    // R10/R11 merge during an outstanding message
    wr(0, 32'h8000_00A7);
    lines[0] = 1; wait_cyc(5);
    check("R11 first req", {31'd0, mreq}, 1);
    check("R9 data 2", mdata, 32'h07);
    check("R9 addr 2", maddr, 32'h8000_00A0);
    lines[1] = 1; wait_cyc(5); lines[2] = 1; wait_cyc(5);
    check("R10 held", {31'd0, mreq}, 1);
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
    check("R10 low after ack", {31'd0, mreq}, 0);
    @(negedge clk);
    check("R11 follow-up", {31'd0, mreq}, 1);
    rd(2, v); check("R11 accumulated", v, 32'h007);
    do_ack; wait_cyc(4);
    check("R11 only one follow-up", {31'd0, mreq}, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule